// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block is the hazard controller of a five-stage in-order integer pipeline with fetch, decode, execute, memory and writeback stages. It looks at the register numbers that the instruction in decode reads and at the register numbers that the instruction in execute reads. It also looks at the destination, write-enable and load flag carried in each of the three later pipeline registers. From these it sets the operand bypass selects for the ALU and decides whether the decode instruction may issue.

Each hazard is found while the instruction sits in decode. If it is not safe to issue, the unit holds the PC and the fetch/decode register and places a bubble into execute. Conditional branches are resolved in decode: the unit compares the two operands for equal or not-equal and adds a byte offset to the PC to form the target. Fetch always continues on the fall-through path. When a branch turns out to be taken, the unit flushes the wrongly fetched instruction.

Because the register file writes in the first half of a cycle and reads in the second, a reader three instructions behind a writer needs no bypass.

Top module: `pipe_hazard_unit`

## Requirements
- R1: If the execute source register matches the EX/MEM destination, the operand select is 2'b10. A match needs a nonzero destination with its write enable set.
- R2: If the execute source register matches only the MEM/WB destination, the operand select is 2'b01. This also covers a load whose result is now in MEM/WB. With no match, the select is 2'b00 (register file value).
- R3: When EX/MEM and MEM/WB both match the same source, the select is 2'b10, so the younger value wins.
- R4: Register 0, and any destination whose write enable is clear, never causes a bypass or a stall.
- R5: Suppose the ID/EX entry is a load and its destination equals a decode source that is marked as used. Then stall_o and bubble_o are both 1 in that same cycle. A source not marked as used never stalls.
- R6: A load held in EX/MEM never stalls a non-branch reader in decode.
- R7: A writer held in MEM/WB never causes a stall.
- R8: A valid decode branch whose operands are ready is taken under two conditions. For the equal kind (id_br_ne_i=0), the operands must be equal. For the not-equal kind (id_br_ne_i=1), they must differ. When taken, redirect_o and flush_o are both 1 in that cycle, and target_o equals id_pc_i + id_imm_i.
- R9: A decode branch stalls, with no redirect, in two cases. One is when a used source matches the ID/EX destination. The other is when a used source matches an EX/MEM load destination.
- R10: A decode branch compares using the EX/MEM ALU value for any source that matches a non-load EX/MEM destination.
- R11: In the cycle after a redirect, the decode instruction is treated as a no-op: no stall and no redirect. After that cycle, and after reset, normal detection applies.
- R12: When id_valid_i is 0, stall_o, bubble_o, redirect_o and flush_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | Decode holds an instruction |
| id_rs1_i | input | AW | Decode source 1 register |
| id_rs2_i | input | AW | Decode source 2 register |
| id_use_rs1_i | input | 1 | Decode reads source 1 |
| id_use_rs2_i | input | 1 | Decode reads source 2 |
| id_is_branch_i | input | 1 | Decode instruction is a conditional branch |
| id_br_ne_i | input | 1 | Branch kind: 0 equal, 1 not-equal |
| id_pc_i | input | XLEN | PC of the decode instruction |
| id_imm_i | input | XLEN | Branch byte offset |
| id_rs1_val_i | input | XLEN | Register file value of source 1 |
| id_rs2_val_i | input | XLEN | Register file value of source 2 |
| ex_rs1_i | input | AW | Execute source 1 register |
| ex_rs2_i | input | AW | Execute source 2 register |
| idex_rd_i | input | AW | ID/EX destination |
| idex_we_i | input | 1 | ID/EX write enable |
| idex_load_i | input | 1 | ID/EX is a load |
| exmem_rd_i | input | AW | EX/MEM destination |
| exmem_we_i | input | 1 | EX/MEM write enable |
| exmem_load_i | input | 1 | EX/MEM is a load |
| exmem_alu_i | input | XLEN | EX/MEM ALU result |
| memwb_rd_i | input | AW | MEM/WB destination |
| memwb_we_i | input | 1 | MEM/WB write enable |
| fwd_a_o | output | 2 | Operand A select |
| fwd_b_o | output | 2 | Operand B select |
| stall_o | output | 1 | Hold PC and IF/ID |
| bubble_o | output | 1 | Insert no-op into ID/EX |
| redirect_o | output | 1 | Load PC from target_o |
| flush_o | output | 1 | Turn IF/ID into a no-op |
| target_o | output | XLEN | Branch target |

## Verification
The bypass selects, stall, bubble, redirect, flush and target are all combinational in the current inputs, so each result is due in the same cycle its stimulus is applied. The bench drives each vector just after a rising edge and compares at the following falling edge of that same cycle. The squash of the instruction after a taken branch is the only registered effect. It is due one cycle after the redirect, so the bench drives the next vector one cycle later with a hazard present and expects no stall. It then repeats that vector in the cycle after and expects the stall.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] exmem_rd_i,
  input  logic          exmem_we_i,
  input  logic [AW-1:0] memwb_rd_i,
  input  logic          memwb_we_i,
  output fwd_sel_e      sel_o
);
  logic hit_mem, hit_wb;

  assign hit_mem = exmem_we_i && (exmem_rd_i != '0) && (exmem_rd_i == src_i);
  assign hit_wb  = memwb_we_i && (memwb_rd_i != '0) && (memwb_rd_i == src_i);

  // younger producer wins
  always_comb begin
    if (hit_mem)     sel_o = FWD_MEM;
    else if (hit_wb) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic                     dec_ok_i,
  input  logic [NSRC-1:0][AW-1:0]  src_i,
  input  logic [NSRC-1:0]          use_i,
  input  logic                     is_branch_i,
  input  logic [AW-1:0]            idex_rd_i,
  input  logic                     idex_we_i,
  input  logic                     idex_load_i,
  input  logic [AW-1:0]            exmem_rd_i,
  input  logic                     exmem_we_i,
  input  logic                     exmem_load_i,
  output logic                     stall_o,
  output logic [NSRC-1:0]          br_fwd_o
);
  logic [NSRC-1:0] load_use, br_wait;
  logic            idex_live, exmem_live;

  assign idex_live  = idex_we_i && (idex_rd_i != '0);
  assign exmem_live = exmem_we_i && (exmem_rd_i != '0);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic hit_ex, hit_mem;
    assign hit_ex      = idex_live && use_i[s] && (src_i[s] == idex_rd_i);
    assign hit_mem     = exmem_live && use_i[s] && (src_i[s] == exmem_rd_i);
    assign load_use[s] = hit_ex && idex_load_i;
    // branch reads in decode: ALU result not ready, load data not ready
    assign br_wait[s]  = is_branch_i && (hit_ex || (hit_mem && exmem_load_i));
    assign br_fwd_o[s] = hit_mem && !exmem_load_i;
  end

  assign stall_o = dec_ok_i && ((|load_use) || (|br_wait));
endmodule

// File: rtl/hz_branch_unit.sv
module hz_branch_unit #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  input  logic [XLEN-1:0] exmem_alu_i,
  input  logic [1:0]      fwd_i,
  input  logic            is_ne_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] imm_i,
  output logic            taken_o,
  output logic [XLEN-1:0] target_o
);
  logic [XLEN-1:0] op1, op2;
  logic            same;

  assign op1      = fwd_i[0] ? exmem_alu_i : rs1_val_i;
  assign op2      = fwd_i[1] ? exmem_alu_i : rs2_val_i;
  assign same     = (op1 == op2);
  assign taken_o  = is_ne_i ? !same : same;
  assign target_o = pc_i + imm_i;
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hz_pkg::*;
#(
  parameter int AW   = 5,
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            id_valid_i,
  input  logic [AW-1:0]   id_rs1_i,
  input  logic [AW-1:0]   id_rs2_i,
  input  logic            id_use_rs1_i,
  input  logic            id_use_rs2_i,
  input  logic            id_is_branch_i,
  input  logic            id_br_ne_i,
  input  logic [XLEN-1:0] id_pc_i,
  input  logic [XLEN-1:0] id_imm_i,
  input  logic [XLEN-1:0] id_rs1_val_i,
  input  logic [XLEN-1:0] id_rs2_val_i,
  input  logic [AW-1:0]   ex_rs1_i,
  input  logic [AW-1:0]   ex_rs2_i,
  input  logic [AW-1:0]   idex_rd_i,
  input  logic            idex_we_i,
  input  logic            idex_load_i,
  input  logic [AW-1:0]   exmem_rd_i,
  input  logic            exmem_we_i,
  input  logic            exmem_load_i,
  input  logic [XLEN-1:0] exmem_alu_i,
  input  logic [AW-1:0]   memwb_rd_i,
  input  logic            memwb_we_i,
  output logic [1:0]      fwd_a_o,
  output logic [1:0]      fwd_b_o,
  output logic            stall_o,
  output logic            bubble_o,
  output logic            redirect_o,
  output logic            flush_o,
  output logic [XLEN-1:0] target_o
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][AW-1:0] ex_src, id_src;
  logic [NSRC-1:0]         id_use, br_fwd;
  fwd_sel_e [NSRC-1:0]     ex_sel;
  logic                    kill_q, dec_ok, stall, taken;

  assign ex_src = {ex_rs2_i, ex_rs1_i};
  assign id_src = {id_rs2_i, id_rs1_i};
  assign id_use = {id_use_rs2_i, id_use_rs1_i};

  for (genvar s = 0; s < NSRC; s++) begin : g_fwd
    hz_fwd_sel #(.AW(AW)) i_fwd (
      .src_i      (ex_src[s]),
      .exmem_rd_i (exmem_rd_i),
      .exmem_we_i (exmem_we_i),
      .memwb_rd_i (memwb_rd_i),
      .memwb_we_i (memwb_we_i),
      .sel_o      (ex_sel[s])
    );
  end

  assign fwd_a_o = ex_sel[0];
  assign fwd_b_o = ex_sel[1];

  // decode slot squashed after a taken branch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kill_q <= 1'b0;
    else         kill_q <= redirect_o;
  end

  assign dec_ok = id_valid_i && !kill_q;

  hz_interlock #(.AW(AW), .NSRC(NSRC)) i_lock (
    .dec_ok_i     (dec_ok),
    .src_i        (id_src),
    .use_i        (id_use),
    .is_branch_i  (id_is_branch_i),
    .idex_rd_i    (idex_rd_i),
    .idex_we_i    (idex_we_i),
    .idex_load_i  (idex_load_i),
    .exmem_rd_i   (exmem_rd_i),
    .exmem_we_i   (exmem_we_i),
    .exmem_load_i (exmem_load_i),
    .stall_o      (stall),
    .br_fwd_o     (br_fwd)
  );

  hz_branch_unit #(.XLEN(XLEN)) i_br (
    .rs1_val_i   (id_rs1_val_i),
    .rs2_val_i   (id_rs2_val_i),
    .exmem_alu_i (exmem_alu_i),
    .fwd_i       (br_fwd),
    .is_ne_i     (id_br_ne_i),
    .pc_i        (id_pc_i),
    .imm_i       (id_imm_i),
    .taken_o     (taken),
    .target_o    (target_o)
  );

  assign stall_o    = stall;
  assign bubble_o   = stall;
  // stall wins over redirect
  assign redirect_o = dec_ok && id_is_branch_i && taken && !stall;
  assign flush_o    = redirect_o;
endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
  parameter int AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          id_valid_i,
  input logic [AW-1:0] id_rs1_i,
  input logic          id_use_rs1_i,
  input logic          id_is_branch_i,
  input logic [AW-1:0] ex_rs1_i,
  input logic [AW-1:0] idex_rd_i,
  input logic          idex_we_i,
  input logic          idex_load_i,
  input logic [AW-1:0] exmem_rd_i,
  input logic          exmem_we_i,
  input logic [1:0]    fwd_a_o,
  input logic          stall_o,
  input logic          bubble_o,
  input logic          redirect_o,
  input logic          flush_o
);
  assert_prio_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exmem_we_i && exmem_rd_i != '0 && exmem_rd_i == ex_rs1_i) |-> fwd_a_o == 2'b10);

  assert_x0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rs1_i == '0) |-> fwd_a_o == 2'b00);

  assert_load_use_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_i && !$past(redirect_o) && idex_load_i && idex_we_i && idex_rd_i != '0
     && id_use_rs1_i && id_rs1_i == idex_rd_i) |-> (stall_o && bubble_o));

  assert_redirect_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (flush_o && id_is_branch_i && id_valid_i));

  assert_squash_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(redirect_o) |-> (!stall_o && !redirect_o));

  assert_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_valid_i |-> (!stall_o && !redirect_o));
endmodule

bind pipe_hazard_unit hz_checker #(.AW(AW)) i_hz_checker (.*);

// File: tb/test_pipe_hazard_unit.sv
module test_pipe_hazard_unit;
  localparam int AW = 5;
  localparam int XLEN = 32;

  typedef struct {
    logic [1:0]      fa;
    logic [1:0]      fb;
    logic            st;
    logic            rd;
    logic [XLEN-1:0] tg;
    string           req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic id_valid, id_use1, id_use2, id_br, id_ne;
  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, idex_rd, exmem_rd, memwb_rd;
  logic [XLEN-1:0] id_pc, id_imm, v1, v2, exmem_alu;
  logic idex_we, idex_ld, exmem_we, exmem_ld, memwb_we;
  logic [1:0] fwd_a, fwd_b;
  logic stall, bubble, redirect, flush;
  logic [XLEN-1:0] target;

  exp_t q[$];
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pipe_hazard_unit #(.AW(AW), .XLEN(XLEN)) i_pipe_hazard_unit (
    .clk_i(clk), .rst_ni(rst_n), .id_valid_i(id_valid),
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .id_use_rs1_i(id_use1), .id_use_rs2_i(id_use2),
    .id_is_branch_i(id_br), .id_br_ne_i(id_ne), .id_pc_i(id_pc), .id_imm_i(id_imm),
    .id_rs1_val_i(v1), .id_rs2_val_i(v2), .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2),
    .idex_rd_i(idex_rd), .idex_we_i(idex_we), .idex_load_i(idex_ld),
    .exmem_rd_i(exmem_rd), .exmem_we_i(exmem_we), .exmem_load_i(exmem_ld),
    .exmem_alu_i(exmem_alu), .memwb_rd_i(memwb_rd), .memwb_we_i(memwb_we),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .stall_o(stall), .bubble_o(bubble),
    .redirect_o(redirect), .flush_o(flush), .target_o(target)
  );

  task automatic idle();
    id_valid = 1; id_use1 = 0; id_use2 = 0; id_br = 0; id_ne = 0;
    id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0;
    idex_rd = 0; exmem_rd = 0; memwb_rd = 0;
    id_pc = 0; id_imm = 0; v1 = 0; v2 = 0; exmem_alu = 0;
    idex_we = 0; idex_ld = 0; exmem_we = 0; exmem_ld = 0; memwb_we = 0;
  endtask

  task automatic cyc();
    @(posedge clk); #1; idle();
  endtask

  task automatic expect_o(input logic [1:0] fa, input logic [1:0] fb, input logic st,
                          input logic rd, input logic [XLEN-1:0] tg, input string req);
    exp_t e;
    e.fa = fa; e.fb = fb; e.st = st; e.rd = rd; e.tg = tg; e.req = req;
    q.push_back(e);
  endtask

  task automatic chk(input string what, input string req, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("fwd_a", e.req, {30'd0, fwd_a}, {30'd0, e.fa});
      chk("fwd_b", e.req, {30'd0, fwd_b}, {30'd0, e.fb});
      chk("stall", e.req, {31'd0, stall}, {31'd0, e.st});
      chk("bubble", e.req, {31'd0, bubble}, {31'd0, e.st});
      chk("redirect", e.req, {31'd0, redirect}, {31'd0, e.rd});
      chk("flush", e.req, {31'd0, flush}, {31'd0, e.rd});
      if (e.rd) chk("target", e.req, target, e.tg);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1..: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (2) @(posedge clk);
    #1; expect_o(2'b00, 2'b00, 0, 0, 0, "reset R11");
    @(posedge clk); #1 rst_n = 1'b1;

    cyc(); ex_rs1 = 3; exmem_rd = 3; exmem_we = 1;
    expect_o(2'b10, 2'b00, 0, 0, 0, "R1");
    cyc(); ex_rs2 = 4; memwb_rd = 4; memwb_we = 1;
    expect_o(2'b00, 2'b01, 0, 0, 0, "R2");
    cyc(); ex_rs1 = 5; ex_rs2 = 5; exmem_rd = 5; exmem_we = 1; memwb_rd = 5; memwb_we = 1;
    expect_o(2'b10, 2'b10, 0, 0, 0, "R3");
    cyc(); exmem_we = 1; memwb_we = 1; idex_we = 1; idex_ld = 1; id_use1 = 1;
    expect_o(2'b00, 2'b00, 0, 0, 0, "R4 reg0");
    cyc(); ex_rs1 = 3; exmem_rd = 3; idex_rd = 3; idex_ld = 1; id_rs1 = 3; id_use1 = 1;
    expect_o(2'b00, 2'b00, 0, 0, 0, "R4 we clear");
    cyc(); idex_rd = 7; idex_we = 1; idex_ld = 1; id_rs2 = 7; id_use2 = 1;
    expect_o(2'b00, 2'b00, 1, 0, 0, "R5 load use");
    cyc(); idex_rd = 7; idex_we = 1; idex_ld = 1; id_rs2 = 7;
    expect_o(2'b00, 2'b00, 0, 0, 0, "R5 unused source");
    cyc(); exmem_rd = 7; exmem_we = 1; exmem_ld = 1; id_rs1 = 7; id_use1 = 1;
    expect_o(2'b00, 2'b00, 0, 0, 0, "R6");
    cyc(); memwb_rd = 7; memwb_we = 1; id_rs1 = 7; id_use1 = 1; id_br = 1; v1 = 1; v2 = 2;
    expect_o(2'b00, 2'b00, 0, 0, 0, "R7");

    cyc(); id_br = 1; id_use1 = 1; id_use2 = 1; id_rs1 = 1; id_rs2 = 2; v1 = 9; v2 = 9;
    id_pc = 32'h100; id_imm = 32'h20;
    expect_o(2'b00, 2'b00, 0, 1, 32'h120, "R8 equal taken");
    cyc(); idex_rd = 7; idex_we = 1; idex_ld = 1; id_rs1 = 7; id_use1 = 1;
    expect_o(2'b00, 2'b00, 0, 0, 0, "R11 squashed slot");
    cyc(); idex_rd = 7; idex_we = 1; idex_ld = 1; id_rs1 = 7; id_use1 = 1;
    expect_o(2'b00, 2'b00, 1, 0, 0, "R11 squash cleared");

    cyc(); id_br = 1; id_ne = 1; id_use1 = 1; id_use2 = 1; id_rs1 = 1; id_rs2 = 2;
    v1 = 3; v2 = 4; id_pc = 32'h200; id_imm = 32'hFFFF_FFF0;
    expect_o(2'b00, 2'b00, 0, 1, 32'h1F0, "R8 not-equal taken");
    cyc(); expect_o(2'b00, 2'b00, 0, 0, 0, "R11 idle after branch");
    cyc(); id_br = 1; id_use1 = 1; id_use2 = 1; id_rs1 = 1; id_rs2 = 2; v1 = 3; v2 = 4;
    expect_o(2'b00, 2'b00, 0, 0, 0, "R8 equal not taken");

    cyc(); id_br = 1; id_use1 = 1; id_use2 = 1; id_rs1 = 6; id_rs2 = 2; v1 = 5; v2 = 5;
    idex_rd = 6; idex_we = 1;
    expect_o(2'b00, 2'b00, 1, 0, 0, "R9 alu producer in EX");
    cyc(); id_br = 1; id_use1 = 1; id_use2 = 1; id_rs1 = 1; id_rs2 = 6; v1 = 5; v2 = 5;
    exmem_rd = 6; exmem_we = 1; exmem_ld = 1;
    expect_o(2'b00, 2'b00, 1, 0, 0, "R9 load in MEM");
    cyc(); id_br = 1; id_use1 = 1; id_use2 = 1; id_rs1 = 6; id_rs2 = 2; v1 = 1; v2 = 9;
    exmem_rd = 6; exmem_we = 1; exmem_alu = 9; id_pc = 32'h40; id_imm = 32'h8;
    expect_o(2'b00, 2'b00, 0, 1, 32'h48, "R10 bypass into compare");
    cyc(); expect_o(2'b00, 2'b00, 0, 0, 0, "R11 idle after branch");
    cyc(); id_valid = 0; idex_rd = 7; idex_we = 1; idex_ld = 1; id_rs1 = 7; id_use1 = 1;
    id_br = 1; v1 = 1; v2 = 1;
    expect_o(2'b00, 2'b00, 0, 0, 0, "R12");

    cyc();
    repeat (2) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule